// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Front-End

This block models the control and address front-end of a pipelined synchronous burst SRAM with a data word split into byte lanes. On every rising clock edge it samples two active-low address strobes, a primary active-low select, two secondary selects, an advance input, the write enables and a burst-order input. From these it classifies the cycle, updates a burst address counter and a small internal byte-lane array, and drives read data through a two-stage pipeline with an output enable.

A controller FSM holds one of three states: `ST_IDLE` (deselected), `ST_RD` (read burst) and `ST_WR` (write burst). Each edge is classified as one of six transitions: `CY_LOAD_RD` and `CY_LOAD_WR` load a new external address and go to `ST_RD` or `ST_WR`. `CY_ADV_RD` and `CY_ADV_WR` step the burst counter and go to `ST_RD` or `ST_WR`. `CY_DESEL` goes to `ST_IDLE`. `CY_HOLD` keeps the current state and address. The read-only strobe wins over the read/write strobe. It is honoured only while the primary select is low.

Reads and the output enable both trail the address by two edges. A deselect therefore leaves the bus driven for two more cycles before it is released.

Top module: `burst_sram_front`

## Requirements
- R1: During and straight after reset, `oe_o` is 0 and `rdata_o` is 0.
- R2: `strobe_rd_n` low with `sel_n` low, `sel_hi` high and `sel_lo_n` low loads `addr_i` and starts a read. `wr_all_n` and `wr_lane_n` have no effect on the array in that cycle.
- R3: While `sel_n` is high, `strobe_rd_n` is ignored. With `strobe_rw_n` and `adv_n` also high, the address and state are held.
- R4: `strobe_rd_n` accepted (`sel_n` low) while `sel_hi` is low or `sel_lo_n` is high deselects the device instead of reading.
- R5: `strobe_rw_n` low with all three selects active loads `addr_i`. It writes if any write enable is asserted, and reads otherwise.
- R6: `strobe_rw_n` low while `sel_n` is high deselects the device.
- R7: With `sel_n` low, `strobe_rd_n` low takes priority over `strobe_rw_n` low: the cycle is a read and nothing is written.
- R8: With `order_il` = 0, each edge with `adv_n` low and no accepted strobe, in a read or write burst, adds 1 modulo 4 to the two low address bits. After four beats the address returns to the start.
- R9: With `order_il` = 1, the two low address bits are the starting low bits XOR a beat count that steps by 1 modulo 4.
- R10: Lane k covers data bits [8k+7:8k]. A write updates lane k only when `wr_lane_n[k]` is 0, unless `wr_all_n` is 0, in which case all lanes are written.
- R11: Read data for an address loaded at edge k is on `rdata_o` with `oe_o` high after edge k+2 and not before.
- R12: After a deselect at edge d that ends a read, `oe_o` stays high after edges d and d+1. It is low after edge d+2, and `rdata_o` is 0 whenever `oe_o` is low.
- R13: An edge with `adv_n` high and no accepted strobe keeps the address, so a read burst repeats the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | External word address |
| strobe_rd_n | input | 1 | Read-only address strobe, active low, highest priority |
| strobe_rw_n | input | 1 | Read/write address strobe, active low |
| sel_n | input | 1 | Primary select, active low |
| sel_hi | input | 1 | Secondary select, active high |
| sel_lo_n | input | 1 | Secondary select, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_n | input | LANES | Per-lane write enables, active low |
| wdata_i | input | 8*LANES | Write data |
| rdata_o | output | 8*LANES | Pipelined read data, 0 when released |
| oe_o | output | 1 | Output enable |

## Verification
The bench targets the strobe priority and gating corners. Both strobes low with writes enabled must leave the array unchanged. A design that let the read/write strobe win would corrupt the word it then reads back. A read-only strobe under a high primary select must leave the held read word on the bus. Burst wrap is checked from a mid-block start in both orders: an off-by-one counter or a carry into the upper address bits shows up as a wrong word on the fifth beat. The output enable is sampled one cycle before and after the expected edges for read latency and for the double-cycle deselect, which exposes a pipeline that is one register short or long.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR
    } state_e;

    typedef enum logic [2:0] {
        CY_HOLD,
        CY_LOAD_RD,
        CY_LOAD_WR,
        CY_ADV_RD,
        CY_ADV_WR,
        CY_DESEL
    } cyc_e;

    // Low two address bits of a burst beat.
    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input logic       il);
        return il ? (start ^ beat) : 2'(start + beat);
    endfunction

endpackage

// File: rtl/bsf_cycle_decode.sv
module bsf_cycle_decode
    import bsf_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             strobe_rd_n,
    input  logic             strobe_rw_n,
    input  logic             sel_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             adv_n,
    input  logic             wr_all_n,
    input  logic [LANES-1:0] wr_lane_n,
    input  logic             burst_active,
    output cyc_e             kind,
    output logic [LANES-1:0] lane_en
);

    logic all_sel;
    logic wr_any;

    always_comb begin
        all_sel = !sel_n && sel_hi && !sel_lo_n;
        lane_en = wr_all_n ? ~wr_lane_n : {LANES{1'b1}};
        wr_any  = |lane_en;
        if (!sel_n && !strobe_rd_n) begin
            kind = all_sel ? CY_LOAD_RD : CY_DESEL;
        end else if (!strobe_rw_n) begin
            if (sel_n || !all_sel) begin
                kind = CY_DESEL;
            end else begin
                kind = wr_any ? CY_LOAD_WR : CY_LOAD_RD;
            end
        end else if (!adv_n && burst_active) begin
            kind = wr_any ? CY_ADV_WR : CY_ADV_RD;
        end else begin
            kind = CY_HOLD;
        end
    end

endmodule

// File: rtl/bsf_burst_addr.sv
module bsf_burst_addr
    import bsf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cyc_e          kind,
    input  logic [AW-1:0] ext_addr,
    input  logic          order_il,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr
);

    logic [AW-1:0] base_q;
    logic [1:0]    beat_q;
    logic [1:0]    beat_nxt;
    logic          do_load;
    logic          do_adv;

    always_comb begin
        do_load  = (kind == CY_LOAD_RD) || (kind == CY_LOAD_WR);
        do_adv   = (kind == CY_ADV_RD) || (kind == CY_ADV_WR);
        beat_nxt = 2'(beat_q + 2'd1);
        cur_addr = base_q;
        cur_addr[1:0] = burst_lo(base_q[1:0], beat_q, order_il);
        if (do_load) begin
            nxt_addr = ext_addr;
        end else if (do_adv) begin
            nxt_addr = base_q;
            nxt_addr[1:0] = burst_lo(base_q[1:0], beat_nxt, order_il);
        end else begin
            nxt_addr = cur_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (do_load) begin
            base_q <= ext_addr;
            beat_q <= '0;
        end else if (do_adv) begin
            beat_q <= beat_nxt;
        end
    end

endmodule

// File: rtl/bsf_lane_array.sv
module bsf_lane_array
    import bsf_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_en,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g]) begin
                cells[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end

endmodule

// File: rtl/bsf_read_pipe.sv
module bsf_read_pipe #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          own_in,
    input  logic [DW-1:0] word_in,
    output logic          oe_o,
    output logic [DW-1:0] rdata_o
);

    logic          s1_own;
    logic [DW-1:0] s1_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_own  <= 1'b0;
            s1_word <= '0;
            oe_o    <= 1'b0;
            rdata_o <= '0;
        end else begin
            s1_own  <= own_in;
            s1_word <= word_in;
            oe_o    <= s1_own;
            rdata_o <= s1_own ? s1_word : '0;
        end
    end

endmodule

// File: rtl/burst_sram_front.sv
module burst_sram_front
    import bsf_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr_i,
    input  logic                    strobe_rd_n,
    input  logic                    strobe_rw_n,
    input  logic                    sel_n,
    input  logic                    sel_hi,
    input  logic                    sel_lo_n,
    input  logic                    order_il,
    input  logic                    adv_n,
    input  logic                    wr_all_n,
    input  logic [LANES-1:0]        wr_lane_n,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    oe_o
);

    localparam int DW = LANES * LANE_W;

    state_e           state_q;
    state_e           state_d;
    cyc_e             kind;
    logic [LANES-1:0] lane_en;
    logic [AW-1:0]    cur_addr;
    logic [AW-1:0]    nxt_addr;
    logic [DW-1:0]    arr_word;
    logic             mem_we;
    logic             rd_own;
    logic             burst_active;

    assign burst_active = (state_q != ST_IDLE);

    bsf_cycle_decode #(.LANES(LANES)) u_decode (
        .strobe_rd_n  (strobe_rd_n),
        .strobe_rw_n  (strobe_rw_n),
        .sel_n        (sel_n),
        .sel_hi       (sel_hi),
        .sel_lo_n     (sel_lo_n),
        .adv_n        (adv_n),
        .wr_all_n     (wr_all_n),
        .wr_lane_n    (wr_lane_n),
        .burst_active (burst_active),
        .kind         (kind),
        .lane_en      (lane_en)
    );

    bsf_burst_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .ext_addr (addr_i),
        .order_il (order_il),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr)
    );

    // Next-state process
    always_comb begin
        unique case (kind)
            CY_LOAD_RD, CY_ADV_RD: state_d = ST_RD;
            CY_LOAD_WR, CY_ADV_WR: state_d = ST_WR;
            CY_DESEL:              state_d = ST_IDLE;
            CY_HOLD:               state_d = state_q;
            default:               state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process
    always_comb begin
        mem_we = (kind == CY_LOAD_WR) || (kind == CY_ADV_WR);
        rd_own = (state_q == ST_RD);
    end

    bsf_lane_array #(.AW(AW), .LANES(LANES)) u_array (
        .clk     (clk),
        .we      (mem_we),
        .lane_en (lane_en),
        .waddr   (nxt_addr),
        .wdata   (wdata_i),
        .raddr   (cur_addr),
        .rdata   (arr_word)
    );

    bsf_read_pipe #(.DW(DW)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .own_in  (rd_own),
        .word_in (arr_word),
        .oe_o    (oe_o),
        .rdata_o (rdata_o)
    );

endmodule

// File: rtl/bsf_checker.sv
module bsf_checker
    import bsf_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strobe_rd_n,
    input logic          strobe_rw_n,
    input logic          sel_n,
    input logic          sel_hi,
    input logic          sel_lo_n,
    input logic          adv_n,
    input logic          order_il,
    input logic          oe_o,
    input logic [DW-1:0] rdata_o,
    input state_e        state_q,
    input cyc_e          kind,
    input logic [AW-1:0] cur_addr,
    input logic          mem_we
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!oe_o && rdata_o == '0));

    p_ignored_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && strobe_rw_n && adv_n) |=> ($stable(cur_addr) && $stable(state_q)));

    p_sub_sel_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !strobe_rd_n && (!sel_hi || sel_lo_n)) |=> (state_q == ST_IDLE));

    p_rw_desel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && !strobe_rw_n) |=> (state_q == ST_IDLE));

    p_rd_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !strobe_rd_n) |-> !mem_we);

    p_linear_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == CY_ADV_RD || kind == CY_ADV_WR) && !order_il)
        |=> (order_il || cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)));

    p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD) |=> ##1 oe_o);

    p_dcd_window_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CY_DESEL && state_q == ST_RD) |=> ##1 (oe_o ##1 !oe_o));

    p_bus_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> (rdata_o == '0));

endmodule

bind burst_sram_front bsf_checker #(.AW(AW), .DW(DW)) u_bsf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_rd_n (strobe_rd_n),
    .strobe_rw_n (strobe_rw_n),
    .sel_n       (sel_n),
    .sel_hi      (sel_hi),
    .sel_lo_n    (sel_lo_n),
    .adv_n       (adv_n),
    .order_il    (order_il),
    .oe_o        (oe_o),
    .rdata_o     (rdata_o),
    .state_q     (state_q),
    .kind        (kind),
    .cur_addr    (cur_addr),
    .mem_we      (mem_we)
);

// File: tb/burst_sram_front_bench.sv
module burst_sram_front_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int LANES = 4;
    localparam int DW = 32;
    localparam int DEPTH = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   addr_i = '0;
    logic            strobe_rd_n = 1'b1;
    logic            strobe_rw_n = 1'b1;
    logic            sel_n = 1'b0;
    logic            sel_hi = 1'b1;
    logic            sel_lo_n = 1'b0;
    logic            order_il = 1'b0;
    logic            adv_n = 1'b1;
    logic            wr_all_n = 1'b1;
    logic [LANES-1:0] wr_lane_n = '1;
    logic [DW-1:0]   wdata_i = '0;
    logic [DW-1:0]   rdata_o;
    logic            oe_o;

    logic [DW-1:0]   ref_mem [DEPTH];
    int              n_checks = 0;
    int              n_fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_sram_front #(.AW(AW), .LANES(LANES)) u_burst_sram_front (
        .clk, .rst_n, .addr_i, .strobe_rd_n, .strobe_rw_n, .sel_n, .sel_hi,
        .sel_lo_n, .order_il, .adv_n, .wr_all_n, .wr_lane_n, .wdata_i,
        .rdata_o, .oe_o
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic idle();
        strobe_rd_n = 1'b1; strobe_rw_n = 1'b1;
        sel_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
        adv_n = 1'b1; wr_all_n = 1'b1; wr_lane_n = '1;
    endtask

    task automatic settle();
        idle(); sel_n = 1'b1; strobe_rw_n = 1'b0;
        step(); idle(); step(); step(); step();
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    task automatic rw_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic all_n, input logic [LANES-1:0] lanes_n);
        idle(); strobe_rw_n = 1'b0; addr_i = a; wdata_i = d;
        wr_all_n = all_n; wr_lane_n = lanes_n;
        step(); idle();
        for (int k = 0; k < LANES; k++) begin
            if (!all_n || !lanes_n[k]) ref_mem[a][k*8 +: 8] = d[k*8 +: 8];
        end
    endtask

    // R2 R11 R13: read-only strobe, latency and hold
    task automatic t_read_hold(input logic [AW-1:0] a);
        settle();
        strobe_rd_n = 1'b0; addr_i = a;
        step(); idle();
        step();
        check("R11 oe low before k+2", {31'd0, oe_o}, 32'd0);
        step();
        check("R11 oe high at k+2", {31'd0, oe_o}, 32'd1);
        check("R2 read data", rdata_o, ref_mem[a]);
        step();
        check("R13 hold repeats word", rdata_o, ref_mem[a]);
    endtask

    // R2: write enables ignored under the read-only strobe
    task automatic t_rd_ignores_wr();
        settle();
        strobe_rd_n = 1'b0; addr_i = 4'd5; wr_all_n = 1'b0; wdata_i = 32'hDEADBEEF;
        step(); idle(); step(); step();
        check("R2 array untouched", rdata_o, ref_mem[5]);
    endtask

    // R7: both strobes, read-only wins
    task automatic t_priority();
        settle();
        strobe_rd_n = 1'b0; strobe_rw_n = 1'b0; addr_i = 4'd12;
        wr_lane_n = 4'b0000; wdata_i = 32'h0BAD0BAD;
        step(); idle(); step(); step();
        check("R7 read wins, no write", rdata_o, ref_mem[12]);
        check("R7 oe", {31'd0, oe_o}, 32'd1);
    endtask

    // R5 R10: lane writes and global override, read back via rw strobe
    task automatic t_lanes();
        settle();
        rw_write(4'd3, 32'h11223344, 1'b1, 4'b1010);
        settle();
        strobe_rw_n = 1'b0; addr_i = 4'd3;
        step(); idle(); step(); step();
        check("R10 lanes 0 and 2 only", rdata_o, ref_mem[3]);
        check("R5 rw strobe read", {31'd0, oe_o}, 32'd1);
        settle();
        rw_write(4'd3, 32'hCAFEF00D, 1'b0, 4'b1111);
        t_read_hold(4'd3);
        check("R10 global write all lanes", rdata_o, 32'hCAFEF00D);
    endtask

    // R8 R9: burst order with wrap
    task automatic t_burst(input logic il, input logic [AW-1:0] start, input string req);
        settle();
        order_il = il;
        strobe_rd_n = 1'b0; addr_i = start;
        step(); idle();
        for (int i = 1; i <= 6; i++) begin
            adv_n = (i <= 4) ? 1'b0 : 1'b1;
            step();
            if (i >= 2) begin
                int beat;
                logic [AW-1:0] ea;
                beat = (i - 2 > 4) ? 4 : i - 2;
                ea = start;
                ea[1:0] = il ? (start[1:0] ^ 2'(beat)) : 2'(start[1:0] + 2'(beat));
                check(req, rdata_o, ref_mem[ea]);
            end
        end
        idle();
        order_il = 1'b0;
    endtask

    // R3: read-only strobe under high primary select is ignored
    task automatic t_gate();
        t_read_hold(4'd9);
        strobe_rd_n = 1'b0; sel_n = 1'b1; addr_i = 4'd2;
        step(); idle(); step(); step();
        check("R3 strobe ignored, word kept", rdata_o, ref_mem[9]);
        check("R3 oe kept", {31'd0, oe_o}, 32'd1);
    endtask

    // R4 R6 R12: deselect paths and double-cycle release
    task automatic t_desel(input logic via_rw);
        t_read_hold(4'd7);
        if (via_rw) begin
            strobe_rw_n = 1'b0; sel_n = 1'b1;
        end else begin
            strobe_rd_n = 1'b0; sel_hi = 1'b0;
        end
        addr_i = 4'd1;
        step(); idle();
        check(via_rw ? "R6 oe after d" : "R4 oe after d", {31'd0, oe_o}, 32'd1);
        step();
        check("R12 oe after d+1", {31'd0, oe_o}, 32'd1);
        check("R12 data after d+1", rdata_o, ref_mem[7]);
        step();
        check("R12 oe low after d+2", {31'd0, oe_o}, 32'd0);
        check("R12 bus released", rdata_o, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        #(CLK_PERIOD/4);
        step(); step();
        check("R1 oe in reset", {31'd0, oe_o}, 32'd0);
        check("R1 data in reset", rdata_o, 32'd0);
        rst_n = 1'b1;
        step();
        check("R1 oe after reset", {31'd0, oe_o}, 32'd0);
        for (int i = 0; i < DEPTH; i++) begin
            rw_write(AW'(i), 32'h9E3779B9 * 32'(i + 1), 1'b0, 4'b1111);
        end
        t_read_hold(4'd0);
        t_read_hold(4'd14);
        t_rd_ignores_wr();
        t_priority();
        t_lanes();
        t_burst(1'b0, 4'd6, "R8 linear beat");
        t_burst(1'b1, 4'd9, "R9 interleaved beat");
        t_gate();
        t_desel(1'b0);
        t_desel(1'b1);
        report();
    end

endmodule